// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer with APB Access

This block is a up-counting timer driven by its own timer clock. A host programs and observes it through an APB3 slave port that runs on a separate, unrelated bus clock. The host selects one of three terminal behaviours: stop at the compare value, reload to zero, or run free. It can also set a compare value, program a prescaler, enable the interrupt, pause and resume counting, and read or load the count.

Every access to a timer-side register crosses clock domains with a toggle handshake. The bus side latches the request and flips a request bit. The timer side applies any write, takes a snapshot of the addressed register and flips an acknowledge bit. The transfer completes only when that acknowledge has been synchronised back, so the count is read safely. A compare match drives a one-cycle pulse in the timer domain. The same match is also carried back to set a sticky status flag, and that flag is the level interrupt on the bus side.

Top module: `mm_timer`

## Requirements
- R1: After both resets, every register reads 0, and `pirq`, `tirq` and `pready` are low.
- R2: Register map by word offset: 0x0 control (bit0 run, bits[2:1] behaviour with 00 stop-at-compare, 01 reload, 10 or 11 free-run, bit3 interrupt enable), 0x4 compare, 0x8 prescaler, 0xC count, 0x10 status. The control, compare and prescaler registers read back the value written. Control reads back only bits[3:0].
- R3: With prescaler value N, the count advances once every N+1 timer clocks while the run bit is set, so N=0 means no division. With the run bit clear, the count holds its value.
- R4: In stop-at-compare mode, the count halts at the compare value and the run bit reads back as 0. The interrupt-enable and mode bits are kept.
- R5: In reload mode, the count returns to 0 on the increment that would make it equal to the compare value C. Matches therefore repeat every C*(N+1) timer clocks.
- R6: In free-run mode, the count passes the compare value without change, wraps from all ones to zero, and the run bit stays set.
- R7: Each match with the interrupt enabled gives one single-cycle pulse on `tirq`. With the interrupt disabled, no pulse occurs.
- R8: Each enabled match sets status bit0, and `pirq` follows that flag as a level. Writing 1 to status bit0 clears the flag; writing 0 leaves it set.
- R9: A write to the count register loads the count, and the loaded value reads back while the timer is stopped.
- R10: Timer-side registers complete only after the handshake round trip, so `pready` is low for at least two wait cycles first. `pready` is high for exactly one bus clock per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 5 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| pirq | output | 1 | Level interrupt in the bus domain (status flag) |
| tclk | input | 1 | Timer clock |
| trst_n | input | 1 | Timer-domain reset, active low |
| tirq | output | 1 | Match pulse in the timer domain |

## Verification
The bench uses the default 32-bit count and 32-bit prescaler, with the timer clock at a different period from the bus clock. Loading the count to a few steps below all ones puts the free-run wrap within reach, even at full width. Compare values of 1 to 8 and prescaler values of 0 to 3, drawn at random, keep reload periods short. That allows the match spacing to be measured exactly on the `tirq` pulses.

// File: rtl/mm_timer.sv
module mm_timer #(
  parameter int CW = 32,
  parameter int PW = 32
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [4:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pirq,
  input  logic        tclk,
  input  logic        trst_n,
  output logic        tirq
);

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_CMP  = 3'd1;
  localparam logic [2:0] IDX_PSC  = 3'd2;
  localparam logic [2:0] IDX_CNT  = 3'd3;
  localparam logic [2:0] IDX_STAT = 3'd4;

  // bus domain
  logic        busy, req_tgl, flag, rw_q;
  logic [2:0]  ra_q;
  logic [31:0] wd_q;
  logic        ack_s1, ack_s2;
  logic        evt_s1, evt_s2, evt_s3;
  // timer domain
  logic          req_s1, req_s2, req_s3, ack_tgl, evt_tgl;
  logic          t_en, t_ie;
  logic [1:0]    t_mode;
  logic [CW-1:0] t_cmp, t_count;
  logic [PW-1:0] t_psc, pcnt;
  logic [31:0]   snap;

  wire [2:0] idx      = paddr[4:2];
  wire       start    = psel & penable & ~busy & ~pready;
  wire       is_local = idx >= IDX_STAT;
  wire       clr      = start & pwrite & (idx == IDX_STAT) & pwdata[0];
  wire       evt_edge = evt_s2 ^ evt_s3;

  assign pirq = flag;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      busy <= 1'b0; req_tgl <= 1'b0; flag <= 1'b0; rw_q <= 1'b0;
      ra_q <= '0; wd_q <= '0; prdata <= '0; pready <= 1'b0;
      ack_s1 <= 1'b0; ack_s2 <= 1'b0;
      evt_s1 <= 1'b0; evt_s2 <= 1'b0; evt_s3 <= 1'b0;
    end else begin
      pready <= 1'b0;
      ack_s1 <= ack_tgl; ack_s2 <= ack_s1;
      evt_s1 <= evt_tgl; evt_s2 <= evt_s1; evt_s3 <= evt_s2;
      if (evt_edge) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (start) begin
        if (is_local) begin
          pready <= 1'b1;
          prdata <= (idx == IDX_STAT) ? {31'd0, flag} : 32'd0;
        end else begin
          busy    <= 1'b1;
          req_tgl <= ~req_tgl;
          ra_q    <= idx;
          wd_q    <= pwdata;
          rw_q    <= pwrite;
        end
      end else if (busy && (ack_s2 == req_tgl)) begin
        busy   <= 1'b0;
        pready <= 1'b1;
        prdata <= snap;
      end
    end
  end

  wire          t_req    = req_s2 ^ req_s3;
  wire          wr       = t_req & rw_q;
  wire          wr_ctrl  = wr & (ra_q == IDX_CTRL);
  wire          wr_cnt   = wr & (ra_q == IDX_CNT);
  wire          tick     = t_en & (pcnt >= t_psc);
  wire [CW-1:0] cnt_inc  = t_count + 1'b1;
  wire          match    = tick & (cnt_inc == t_cmp);
  wire          fire     = match & t_ie;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_s3 <= 1'b0;
      ack_tgl <= 1'b0; evt_tgl <= 1'b0; tirq <= 1'b0;
      t_en <= 1'b0; t_ie <= 1'b0; t_mode <= 2'd0;
      t_cmp <= '0; t_psc <= '0; t_count <= '0; pcnt <= '0; snap <= '0;
    end else begin
      req_s1 <= req_tgl; req_s2 <= req_s1; req_s3 <= req_s2;
      tirq <= fire;
      if (fire) evt_tgl <= ~evt_tgl;

      if (tick) begin
        pcnt <= '0;
        if (match && t_mode == 2'd0) begin
          t_count <= cnt_inc;
          t_en    <= 1'b0;
        end else if (match && t_mode == 2'd1) begin
          t_count <= '0;
        end else begin
          t_count <= cnt_inc;
        end
      end else if (t_en) begin
        pcnt <= pcnt + 1'b1;
      end

      if (t_req) begin
        ack_tgl <= req_s2;
        case (ra_q)
          IDX_CTRL: snap <= {28'd0, t_ie, t_mode, t_en};
          IDX_CMP:  snap <= 32'(t_cmp);
          IDX_PSC:  snap <= 32'(t_psc);
          IDX_CNT:  snap <= 32'(t_count);
          default:  snap <= 32'd0;
        endcase
      end
      if (wr_ctrl) begin
        t_en   <= wd_q[0];
        t_mode <= wd_q[2:1];
        t_ie   <= wd_q[3];
      end
      if (wr & (ra_q == IDX_CMP)) t_cmp <= wd_q[CW-1:0];
      if (wr & (ra_q == IDX_PSC)) t_psc <= wd_q[PW-1:0];
      if (wr_cnt) begin
        t_count <= wd_q[CW-1:0];
        pcnt    <= '0;
      end
    end
  end

endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int CW = 32
) (
  input logic          pclk,
  input logic          presetn,
  input logic          tclk,
  input logic          trst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [4:0]    paddr,
  input logic [31:0]   pwdata,
  input logic          pready,
  input logic          pirq,
  input logic          busy,
  input logic          tirq,
  input logic          t_ie,
  input logic          t_en,
  input logic [1:0]    t_mode,
  input logic          wr_ctrl,
  input logic          wr_cnt,
  input logic [CW-1:0] t_count
);

  // R10
  pready_pulse_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pready |=> !pready);

  // R10
  busy_wait_chk: assert property (@(posedge pclk) disable iff (!presetn)
    busy |-> !pready);

  // R8
  pirq_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (pirq && !(psel && penable && pwrite && paddr[4:2] == 3'd4 && pwdata[0])) |=> pirq);

  // R7
  tirq_gate_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    tirq |-> $past(t_ie));

  // R4
  run_fall_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    $fell(t_en) |-> ($past(t_mode) == 2'd0 || $past(wr_ctrl)));

  // R3
  pause_hold_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (!t_en && !wr_cnt) |=> $stable(t_count));

endmodule

bind mm_timer mm_timer_chk #(.CW(CW)) u_chk (
  .pclk(pclk), .presetn(presetn), .tclk(tclk), .trst_n(trst_n),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
  .pwdata(pwdata), .pready(pready), .pirq(pirq), .busy(busy),
  .tirq(tirq), .t_ie(t_ie), .t_en(t_en), .t_mode(t_mode),
  .wr_ctrl(wr_ctrl), .wr_cnt(wr_cnt), .t_count(t_count)
);

// File: tb/tb_mm_timer.sv
`timescale 1ns/1ps
module tb_mm_timer;
  logic pclk = 0, tclk = 0, presetn = 0, trst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [4:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic pready, pirq, tirq;
  int nchk = 0, nfail = 0;
  int tcyc = 0, npulse = 0, last_t = 0, prev_t = 0;
  logic [31:0] r;
  int wt;

  always #2.5 pclk = ~pclk;
  always #3.5 tclk = ~tclk;

  mm_timer dut (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pirq(pirq), .tclk(tclk), .trst_n(trst_n), .tirq(tirq));

  always @(posedge tclk) tcyc++;
  always @(negedge tclk) if (tirq) begin prev_t = last_t; last_t = tcyc; npulse++; end

  function automatic int exp_period(int c, int n);
    return c * (n + 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb(input bit w, input logic [4:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1; waits = 0;
    forever begin
      @(posedge pclk); #1;
      if (pready) break;
      waits++;
    end
    rd = prdata;
    @(posedge pclk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] x; int k;
    apb(1'b1, a, d, x, k);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    int k;
    apb(1'b0, a, 32'd0, v, k);
  endtask

  task automatic wait_pclk(input int n);
    repeat (n) @(posedge pclk);
  endtask

  task automatic wait_pulses(input int target);
    for (int i = 0; i < 20000 && npulse < target; i++) @(posedge pclk);
  endtask

  initial begin
    #500us;
    nfail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int n0;
    void'($urandom(32'd7351));
    #40; presetn = 1; trst_n = 1;
    #20;
    check(!pirq && !tirq && !pready, "R1 outputs", {pirq, tirq, pready}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      check(v == 0, "R1 reset register", v, 0);
    end

    apb(1'b0, 5'h0C, 0, v, wt);
    check(wt >= 2, "R10 handshake wait", wt, 2);
    #1 check(!pready, "R10 pready single", pready, 0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] c = $urandom, p = $urandom, k = $urandom & 32'he;
      wr(5'h04, c); wr(5'h08, p); wr(5'h00, k);
      rd(5'h04, v); check(v == c, "R2 compare", v, c);
      rd(5'h08, v); check(v == p, "R2 prescaler", v, p);
      rd(5'h00, v); check(v == k, "R2 control", v, k);
    end
    wr(5'h00, 0);

    v2 = $urandom;
    wr(5'h0C, v2);
    rd(5'h0C, v); check(v == v2, "R9 count load", v, v2);
    wait_pclk(50);
    rd(5'h0C, v); check(v == v2, "R3 paused hold", v, v2);

    for (int i = 0; i < 8; i++) begin
      int c = 1 + int'($urandom % 8), p = int'($urandom % 4);
      if (i == 0) begin c = 1; p = 0; end
      if (i == 1) begin c = 3; p = 0; end
      wr(5'h00, 0); wr(5'h0C, 0); wr(5'h04, c); wr(5'h08, p);
      n0 = npulse;
      wr(5'h00, 32'hB);
      wait_pulses(n0 + 3);
      check(last_t - prev_t == exp_period(c, p), "R5 R3 reload period",
            last_t - prev_t, exp_period(c, p));
    end
    wr(5'h00, 0);
    wait_pclk(10);
    rd(5'h10, v); check(v == 1 && pirq, "R8 flag set", {pirq, v[0]}, 2'b11);
    wr(5'h10, 0);
    rd(5'h10, v); check(v == 1 && pirq, "R8 write0 keeps", {pirq, v[0]}, 2'b11);
    wr(5'h10, 1);
    rd(5'h10, v); check(v == 0 && !pirq, "R8 clear", {pirq, v[0]}, 0);

    wr(5'h0C, 0); wr(5'h04, 4); wr(5'h08, 0);
    n0 = npulse;
    wr(5'h00, 32'h3);
    wait_pclk(200);
    wr(5'h00, 0);
    wait_pclk(10);
    check(npulse == n0, "R7 disabled no pulse", npulse - n0, 0);
    rd(5'h10, v); check(v == 0 && !pirq, "R8 disabled no flag", v, 0);

    wr(5'h0C, 0); wr(5'h04, 20); wr(5'h08, 0);
    n0 = npulse;
    wr(5'h00, 32'h9);
    wait_pclk(300);
    rd(5'h0C, v); check(v == 20, "R4 stop at compare", v, 20);
    rd(5'h00, v); check(v == 32'h8, "R4 run cleared", v, 32'h8);
    check(npulse - n0 == 1, "R7 one pulse", npulse - n0, 1);

    wr(5'h0C, 32'hFFFF_FFF0); wr(5'h04, 5); wr(5'h08, 0);
    n0 = npulse;
    wr(5'h00, 32'hD);
    wait_pulses(n0 + 1);
    rd(5'h0C, v); check(v > 5 && v < 2000, "R6 wrapped past compare", v, 6);
    rd(5'h00, v2); check(v2 == 32'hD, "R6 run kept", v2, 32'hD);
    wr(5'h00, 32'hC);
    rd(5'h0C, v); wait_pclk(40);
    rd(5'h0C, v2); check(v2 == v, "R3 pause", v2, v);
    wr(5'h00, 32'hD);
    wait_pclk(40);
    rd(5'h0C, v2); check(v2 > v, "R3 resume", v2, v + 1);
    wr(5'h00, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule